// File: doc/BRIEF.md
# Strided Block Memory Address Pointer Unit

This block generates data-memory addresses for a streaming processor that walks regularly spaced elements of a matrix or image block without spending instructions on address arithmetic. It holds two banks of pointers, one serving the read operand port and one serving the write result port; the size of each bank is a synthesis parameter. Every pointer keeps a root register, which marks the first element of a block, and a walk register, which moves inside that block.

Pointer-control instructions reach the block as a bank select, a pointer index, a data word and two strobes: one loads a new root, the other adds the data word to the walk register. A memory operand reaches a port as a request, a pointer index, a displacement and an auto-step flag. The port returns root plus walk plus displacement in the same cycle. When the auto-step flag is set, the walk register of that pointer advances after the access by a stride that is fixed at synthesis time for that pointer. All arithmetic wraps modulo the memory depth, 2^ADDR_W.

Top module: `blk_addr_ptr_unit`

## Requirements
- R1: After reset every root and walk register is zero, so each port address equals its displacement.
- R2: A port address is root + walk + displacement of the selected pointer. It is combinational and does not depend on the request strobe.
- R3: A root load (ctl_set) writes ctl_data into the root of the named pointer and clears its walk register. The new address is visible from the next cycle.
- R4: A manual step (ctl_inc) adds ctl_data to the walk register of the named pointer.
- R5: A request with the auto-step flag uses the current address in its own cycle, then adds that pointer's fixed stride to its walk register. The default read strides are 1 and 8 for pointers 0 and 1. The default write strides are 1, 16 and 4 for pointers 0, 1 and 2.
- R6: A request without the auto-step flag leaves the pointer unchanged.
- R7: When a root load and a manual or auto step hit the same pointer in one cycle, the root load wins and the walk register becomes zero.
- R8: When a manual step and an auto step hit the same pointer in one cycle, both amounts are added.
- R9: ctl_is_wr selects the bank: 0 for read pointers, 1 for write pointers. Control aimed at one bank leaves the other bank unchanged.
- R10: Control naming one pointer index leaves every other pointer of that bank unchanged.
- R11: Walk sums and port addresses wrap modulo 2^ADDR_W (256 by default).
- R12: A pointer index at or above the bank size reads as zero, so the address equals the displacement. Control and auto steps aimed at such an index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_set | input | 1 | Load root from ctl_data and clear walk |
| ctl_inc | input | 1 | Add ctl_data to walk |
| ctl_is_wr | input | 1 | Bank select for control: 0 read, 1 write |
| ctl_idx | input | IDX_W | Pointer index for control |
| ctl_data | input | ADDR_W | Root value or manual step amount |
| rd_req | input | 1 | Read operand access this cycle |
| rd_idx | input | IDX_W | Read pointer index |
| rd_ofs | input | ADDR_W | Read displacement |
| rd_auto | input | 1 | Auto-step the read pointer after the access |
| rd_addr | output | ADDR_W | Read memory address |
| wr_req | input | 1 | Write result access this cycle |
| wr_idx | input | IDX_W | Write pointer index |
| wr_ofs | input | ADDR_W | Write displacement |
| wr_auto | input | 1 | Auto-step the write pointer after the access |
| wr_addr | output | ADDR_W | Write memory address |

## Verification
The assertions run on every cycle and cover the single-cause updates of pointer 0. They check that a root load shows up as the address, that a lone auto step adds the fixed stride on both ports, and that a lone manual step adds its data. They also check that a quiet cycle or control aimed at the other bank leaves the address steady. The bench scenarios cover the combined cases that no single-cause property describes: root load against step priority, manual plus auto in one cycle, isolation between pointers, wrap-around and out-of-range indices.

// File: rtl/blk_ptr_pkg.sv
// Package: shared helpers for the strided pointer unit.
// Assumes: counts passed in are at least 1.
package blk_ptr_pkg;
    // Width of an index able to name n items, never below one bit.
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Larger of two counts, used to size a shared index field.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/blk_ptr_reg.sv
// Module: one pointer, made of a root register and a walk register.
// Its address is root + walk. A root load clears the walk and takes priority.
// A manual step and an auto step may both land in one cycle and are summed.
// Assumes: all sums wrap at ADDR_W bits.
module blk_ptr_reg #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              inc_i,
    input  logic              auto_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] root_q;
    logic [ADDR_W-1:0] walk_q;
    logic [ADDR_W-1:0] step;

    // Sum the manual and fixed step amounts requested this cycle.
    always_comb begin
        step = '0;
        if (inc_i)  step = step + data_i;
        if (auto_i) step = step + STRIDE;
    end

    // Update the root and walk registers; a root load wins over any step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
            walk_q <= '0;
        end else if (set_i) begin
            root_q <= data_i;
            walk_q <= '0;
        end else if (inc_i || auto_i) begin
            walk_q <= walk_q + step;
        end
    end

    // Form the pointer's base address.
    always_comb addr_o = root_q + walk_q;
endmodule

// File: rtl/blk_ptr_bank.sv
// Module: a bank of NUM pointers serving one memory port.
// It decodes control and auto-step strobes to the named pointer. It also
// selects that pointer's address and adds the operand displacement.
// Assumes: STRIDES packs the stride of pointer i at bits [i*ADDR_W +: ADDR_W].
// An index at or above NUM matches no pointer.
module blk_ptr_bank #(
    parameter int NUM    = 2,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 1,
    parameter logic [NUM*ADDR_W-1:0] STRIDES = {NUM{{{(ADDR_W-1){1'b0}}, 1'b1}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sel,
    input  logic              ctl_set,
    input  logic              ctl_inc,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  logic [ADDR_W-1:0] ctl_data,
    input  logic              acc_req,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [ADDR_W-1:0] acc_ofs,
    input  logic              acc_auto,
    output logic [ADDR_W-1:0] acc_addr
);
    logic [NUM-1:0]    ctl_hit;
    logic [NUM-1:0]    auto_hit;
    logic [ADDR_W-1:0] ptr_addr [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ptr
        assign ctl_hit[g]  = ctl_sel && (ctl_idx == IDX_W'(g));
        assign auto_hit[g] = acc_req && acc_auto && (acc_idx == IDX_W'(g));

        blk_ptr_reg #(
            .ADDR_W (ADDR_W),
            .STRIDE (STRIDES[g*ADDR_W +: ADDR_W])
        ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ctl_hit[g] && ctl_set),
            .inc_i  (ctl_hit[g] && ctl_inc),
            .auto_i (auto_hit[g]),
            .data_i (ctl_data),
            .addr_o (ptr_addr[g])
        );
    end

    // Pick the named pointer (zero when out of range) and add the displacement.
    always_comb begin
        acc_addr = acc_ofs;
        for (int i = 0; i < NUM; i++) begin
            if (acc_idx == IDX_W'(i)) acc_addr = ptr_addr[i] + acc_ofs;
        end
    end
endmodule

// File: rtl/blk_addr_ptr_unit.sv
// Module: top of the strided address pointer unit.
// It holds one bank of read pointers and one bank of write pointers and
// routes the shared control instruction to the bank picked by ctl_is_wr.
// Assumes: memory depth is 2**ADDR_W. Both banks share one index width,
// sized for the larger bank.
module blk_addr_ptr_unit #(
    parameter int NUM_RD = 2,
    parameter int NUM_WR = 3,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = blk_ptr_pkg::idx_bits(blk_ptr_pkg::max2(NUM_RD, NUM_WR)),
    parameter logic [NUM_RD*ADDR_W-1:0] RD_STRIDE = 16'h0801,
    parameter logic [NUM_WR*ADDR_W-1:0] WR_STRIDE = 24'h04_10_01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_set,
    input  logic              ctl_inc,
    input  logic              ctl_is_wr,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  logic [ADDR_W-1:0] ctl_data,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] rd_ofs,
    input  logic              rd_auto,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_ofs,
    input  logic              wr_auto,
    output logic [ADDR_W-1:0] wr_addr
);
    blk_ptr_bank #(
        .NUM     (NUM_RD),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .STRIDES (RD_STRIDE)
    ) u_rd_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_sel  (!ctl_is_wr),
        .ctl_set  (ctl_set),
        .ctl_inc  (ctl_inc),
        .ctl_idx  (ctl_idx),
        .ctl_data (ctl_data),
        .acc_req  (rd_req),
        .acc_idx  (rd_idx),
        .acc_ofs  (rd_ofs),
        .acc_auto (rd_auto),
        .acc_addr (rd_addr)
    );

    blk_ptr_bank #(
        .NUM     (NUM_WR),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .STRIDES (WR_STRIDE)
    ) u_wr_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_sel  (ctl_is_wr),
        .ctl_set  (ctl_set),
        .ctl_inc  (ctl_inc),
        .ctl_idx  (ctl_idx),
        .ctl_data (ctl_data),
        .acc_req  (wr_req),
        .acc_idx  (wr_idx),
        .acc_ofs  (wr_ofs),
        .acc_auto (wr_auto),
        .acc_addr (wr_addr)
    );
endmodule

// File: rtl/blk_ptr_checker.sv
// Module: cycle-by-cycle properties of pointer 0 in both banks, seen at the ports.
// Assumes: it is bound to blk_addr_ptr_unit and receives the same parameters.
module blk_ptr_checker #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter logic [ADDR_W-1:0] RD_S0 = 1,
    parameter logic [ADDR_W-1:0] WR_S0 = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_set,
    input logic              ctl_inc,
    input logic              ctl_is_wr,
    input logic [IDX_W-1:0]  ctl_idx,
    input logic [ADDR_W-1:0] ctl_data,
    input logic              rd_req,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [ADDR_W-1:0] rd_ofs,
    input logic              rd_auto,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [ADDR_W-1:0] wr_ofs,
    input logic              wr_auto,
    input logic [ADDR_W-1:0] wr_addr
);
    logic rd0_ctl, wr0_ctl, rd0_auto, wr0_auto;
    // Classify which events hit pointer 0 of each bank this cycle.
    always_comb begin
        rd0_ctl  = (ctl_set || ctl_inc) && !ctl_is_wr && (ctl_idx == '0);
        wr0_ctl  = (ctl_set || ctl_inc) &&  ctl_is_wr && (ctl_idx == '0);
        rd0_auto = rd_req && rd_auto && (rd_idx == '0);
        wr0_auto = wr_req && wr_auto && (wr_idx == '0);
    end

    assert_root_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_set && !ctl_is_wr && ctl_idx == '0) && rd_idx == '0 && rd_ofs == '0)
        |-> rd_addr == $past(ctl_data));

    assert_rd_auto_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd0_auto && !rd0_ctl) && rd_idx == '0 && $stable(rd_ofs))
        |-> rd_addr == ADDR_W'($past(rd_addr) + RD_S0));

    assert_wr_auto_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr0_auto && !wr0_ctl) && wr_idx == '0 && $stable(wr_ofs))
        |-> wr_addr == ADDR_W'($past(wr_addr) + WR_S0));

    assert_manual_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_inc && !ctl_set && !ctl_is_wr && ctl_idx == '0 && !rd0_auto && rd_idx == '0)
         && rd_idx == '0 && $stable(rd_ofs))
        |-> rd_addr == ADDR_W'($past(rd_addr) + $past(ctl_data)));

    assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rd0_ctl && !rd0_auto && rd_idx == '0) && rd_idx == '0 && $stable(rd_ofs))
        |-> $stable(rd_addr));

    assert_bank_isolation_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_is_wr && !(rd_req && rd_auto)) && $stable(rd_idx) && $stable(rd_ofs))
        |-> $stable(rd_addr));
endmodule

bind blk_addr_ptr_unit blk_ptr_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .RD_S0  (RD_STRIDE[ADDR_W-1:0]),
    .WR_S0  (WR_STRIDE[ADDR_W-1:0])
) u_ptr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_set   (ctl_set),
    .ctl_inc   (ctl_inc),
    .ctl_is_wr (ctl_is_wr),
    .ctl_idx   (ctl_idx),
    .ctl_data  (ctl_data),
    .rd_req    (rd_req),
    .rd_idx    (rd_idx),
    .rd_ofs    (rd_ofs),
    .rd_auto   (rd_auto),
    .rd_addr   (rd_addr),
    .wr_req    (wr_req),
    .wr_idx    (wr_idx),
    .wr_ofs    (wr_ofs),
    .wr_auto   (wr_auto),
    .wr_addr   (wr_addr)
);

// File: tb/test_blk_addr_ptr_unit.sv
// Bench: directed scenarios for the strided pointer unit, one task each.
module test_blk_addr_ptr_unit;
    localparam int AW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_set = 0, ctl_inc = 0, ctl_is_wr = 0;
    logic [IW-1:0] ctl_idx = '0;
    logic [AW-1:0] ctl_data = '0;
    logic          rd_req = 0, rd_auto = 0, wr_req = 0, wr_auto = 0;
    logic [IW-1:0] rd_idx = '0, wr_idx = '0;
    logic [AW-1:0] rd_ofs = '0, wr_ofs = '0;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    blk_addr_ptr_unit i_blk_addr_ptr_unit (
        .clk(clk), .rst_n(rst_n),
        .ctl_set(ctl_set), .ctl_inc(ctl_inc), .ctl_is_wr(ctl_is_wr),
        .ctl_idx(ctl_idx), .ctl_data(ctl_data),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_ofs(rd_ofs), .rd_auto(rd_auto), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_ofs(wr_ofs), .wr_auto(wr_auto), .wr_addr(wr_addr)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Return every input to idle.
    task automatic idle();
        ctl_set = 0; ctl_inc = 0; ctl_is_wr = 0; ctl_idx = '0; ctl_data = '0;
        rd_req = 0; rd_auto = 0; wr_req = 0; wr_auto = 0;
    endtask

    // Let one clock edge take the current inputs, then go idle.
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic ctl(input bit wr, input int idx, input bit s, input bit i, input int d);
        ctl_is_wr = wr; ctl_idx = IW'(idx); ctl_set = s; ctl_inc = i; ctl_data = AW'(d);
        tick();
    endtask

    task automatic rd_look(input int idx, input int ofs, output logic [AW-1:0] a);
        rd_idx = IW'(idx); rd_ofs = AW'(ofs); #1; a = rd_addr;
    endtask

    task automatic wr_look(input int idx, input int ofs, output logic [AW-1:0] a);
        wr_idx = IW'(idx); wr_ofs = AW'(ofs); #1; a = wr_addr;
    endtask

    task automatic t_reset();
        logic [AW-1:0] a;
        rd_look(0, 5, a); chk("R1 rd0 after reset", a, 5);
        rd_look(1, 0, a); chk("R1 rd1 after reset", a, 0);
        wr_look(2, 9, a); chk("R1 wr2 after reset", a, 9);
    endtask

    task automatic t_set();
        logic [AW-1:0] a;
        ctl(0, 1, 1, 0, 40);
        rd_look(1, 0, a); chk("R3 root load rd1", a, 40);
        rd_look(1, 3, a); chk("R2 root+disp rd1", a, 43);
        ctl(0, 1, 0, 1, 5);
        rd_look(1, 0, a); chk("R2 root+walk rd1", a, 45);
        ctl(0, 1, 1, 0, 100);
        rd_look(1, 0, a); chk("R3 load clears walk", a, 100);
    endtask

    task automatic t_inc();
        logic [AW-1:0] a;
        ctl(0, 0, 1, 0, 10);
        ctl(0, 0, 0, 1, 7);
        rd_look(0, 0, a); chk("R4 manual step 1", a, 17);
        ctl(0, 0, 0, 1, 7);
        rd_look(0, 0, a); chk("R4 manual step 2", a, 24);
    endtask

    task automatic t_auto();
        logic [AW-1:0] a;
        ctl(1, 1, 1, 0, 32);
        wr_req = 1; wr_auto = 1;
        wr_look(1, 2, a); chk("R5 pre-step address", a, 34);
        tick();
        wr_look(1, 2, a); chk("R5 stride 16 applied", a, 50);
        wr_req = 1; wr_auto = 0;
        tick();
        wr_look(1, 2, a); chk("R6 access without auto", a, 50);
        rd_req = 1; rd_auto = 1; rd_idx = 1; rd_ofs = 0;
        ctl(0, 1, 1, 0, 0);
        rd_req = 1; rd_auto = 1;
        tick();
        rd_look(1, 0, a); chk("R5 rd1 stride 8", a, 8);
    endtask

    task automatic t_prio();
        logic [AW-1:0] a;
        rd_idx = 0; rd_req = 1; rd_auto = 1;
        ctl(0, 0, 1, 1, 60);
        rd_look(0, 0, a); chk("R7 load beats steps", a, 60);
    endtask

    task automatic t_combo();
        logic [AW-1:0] a;
        ctl(0, 1, 1, 0, 0);
        rd_idx = 1; rd_req = 1; rd_auto = 1;
        ctl(0, 1, 0, 1, 3);
        rd_look(1, 0, a); chk("R8 manual+auto sum", a, 11);
    endtask

    task automatic t_bank();
        logic [AW-1:0] a;
        ctl(0, 0, 1, 0, 5);
        ctl(1, 1, 1, 0, 20);
        ctl(1, 2, 1, 0, 30);
        ctl(1, 0, 1, 0, 77);
        rd_look(0, 0, a); chk("R9 read bank untouched", a, 5);
        wr_look(0, 0, a); chk("R9 write bank loaded", a, 77);
        wr_look(1, 0, a); chk("R10 wr1 untouched", a, 20);
        wr_look(2, 0, a); chk("R10 wr2 untouched", a, 30);
        ctl(1, 2, 0, 1, 4);
        wr_look(1, 0, a); chk("R10 wr1 after wr2 step", a, 20);
    endtask

    task automatic t_wrap();
        logic [AW-1:0] a;
        ctl(0, 0, 1, 0, 250);
        ctl(0, 0, 0, 1, 10);
        rd_look(0, 0, a);   chk("R11 walk wraps", a, 4);
        rd_look(0, 255, a); chk("R11 displacement wraps", a, 3);
    endtask

    task automatic t_range();
        logic [AW-1:0] a;
        ctl(1, 0, 1, 0, 12);
        wr_look(3, 6, a); chk("R12 wr idx3 reads zero", a, 6);
        ctl(1, 3, 1, 0, 99);
        ctl(1, 3, 0, 1, 9);
        wr_idx = 3; wr_req = 1; wr_auto = 1;
        tick();
        wr_look(3, 6, a); chk("R12 wr idx3 still zero", a, 6);
        wr_look(0, 0, a); chk("R12 wr0 untouched", a, 12);
        rd_look(2, 1, a); chk("R12 rd idx2 reads zero", a, 1);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_set();
        t_inc();
        t_auto();
        t_prio();
        t_combo();
        t_bank();
        t_wrap();
        t_range();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule